// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block turns a two-wire serial audio stream (a frame clock and a data line) into parallel stereo PCM words. It runs entirely on the system clock. A one-cycle bit tick marks each rising edge of the bit clock; that tick may come from a local divider or from a synchronized external bit clock. On each tick the block samples the frame clock and the data line.

One shift path serves both I2S framing and left-justified framing. A single select input chooses between them. I2S framing has a one-bit delay and takes the left channel while the frame clock is low. Left-justified framing has no delay and takes the left channel while the frame clock is high. The word length is selectable: 16, 18, 20 or 24 bits. A frame may carry 32, 48, 64 or 72 bit ticks. The block needs no frame-length setting, because every change of the frame clock restarts the slot bit counter.

The output is a left/right word pair with a one-cycle valid strobe. It has no ready input: a serial link cannot be paused, so back-pressure is not possible. A consumer must take each pair in the cycle its strobe is high. The outputs then hold that pair until the next strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: The frame clock and data line are sampled only in cycles where `bit_tick` is high. Their values in any other cycle have no effect on the outputs.
- R2: Within a slot the most significant bit arrives first. Slot bit k (k = 0 is the first bit) lands at output bit 23-k.
- R3: With `fmt_left_just` = 0 (I2S), a slot's first bit is the one sampled on the tick after the tick that first sees the new frame-clock level. The left channel is the slot that starts after the frame clock falls to 0.
- R4: With `fmt_left_just` = 1 (left-justified), a slot's first bit is the one sampled on the tick that first sees the new frame-clock level. The left channel is the slot with the frame clock at 1.
- R5: `word_sel` sets the word length: 2'b00 = 16, 2'b01 = 18, 2'b10 = 20, 2'b11 = 24 bits. Slot bits at and beyond that length are ignored. Output bits below the word are 0.
- R6: `pair_valid` is high for exactly one cycle: the cycle after the tick that carried the right word's last bit. Both words change in that same cycle and hold otherwise.
- R7: Frames of 32, 48, 64 and 72 ticks all decode correctly. This includes I2S with 16-bit words at 32 ticks per frame, where the right word's last bit falls on the tick that sees the frame clock return to 0.
- R8: After reset, `pair_valid` is 0 and both words are 0. No pair is issued until a slot start has been seen and a full left word has been taken ahead of the right word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit-clock rising edge |
| frame_clk | input | 1 | Frame (left/right) clock from the link |
| ser_data | input | 1 | Serial data line |
| fmt_left_just | input | 1 | 0 = I2S framing, 1 = left-justified framing |
| word_sel | input | 2 | Word length select (see R5) |
| left_word | output | 24 | Left sample, MSB-aligned |
| right_word | output | 24 | Right sample, MSB-aligned |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The assertions check on every cycle the parts of the protocol that are local in time:
- the strobe lasts a single cycle and follows a tick that ended a right word;
- the outputs hold between strobes;
- the slot counter restarts on every frame-clock change and stays in range;
- no pair is issued before a slot start has been seen.

Only the bench scenarios can show that the bits land in the right positions. The same goes for the per-format delay and channel polarity, the masking of bits past the word length, and correct decoding at each frame length. The bench also toggles the inputs between ticks to show that off-tick values are ignored.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {FMT_I2S = 1'b0, FMT_LJ = 1'b1} sar_fmt_e;

  function automatic int sar_word_bits(input logic [1:0] sel);
    case (sel)
      2'b00:   return 16;
      2'b01:   return 18;
      2'b10:   return 20;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/sar_slot_track.sv
module sar_slot_track #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             frame_clk,
  input  logic             fmt_lj,
  output logic             slot_start,
  output logic [CNT_W-1:0] slot_idx,
  output logic             slot_left,
  output logic             synced
);
  localparam logic [CNT_W-1:0] IDX_MAX = CNT_W'(SAMPLE_W);

  logic             fclk_d;
  logic             lvl_q;
  logic             sync_q;
  logic [CNT_W-1:0] cnt;
  logic             lvl_eff;

  // I2S looks at the frame clock one tick late, which gives its one-bit delay
  assign lvl_eff    = fmt_lj ? frame_clk : fclk_d;
  assign slot_start = bit_tick && (lvl_eff != lvl_q);
  assign slot_idx   = slot_start ? '0 : cnt;
  assign slot_left  = (lvl_eff == fmt_lj);
  assign synced     = sync_q || slot_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fclk_d <= 1'b0;
      lvl_q  <= 1'b0;
      sync_q <= 1'b0;
      cnt    <= '0;
    end else if (bit_tick) begin
      fclk_d <= frame_clk;
      lvl_q  <= lvl_eff;
      if (slot_start) sync_q <= 1'b1;
      cnt    <= (slot_idx == IDX_MAX) ? IDX_MAX : slot_idx + CNT_W'(1);
    end
  end

  AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> (cnt == CNT_W'(1))); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= IDX_MAX); // R7
endmodule

// File: rtl/sar_shift.sv
module sar_shift #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                ser_data,
  input  logic                slot_start,
  input  logic [CNT_W-1:0]    slot_idx,
  input  logic [CNT_W-1:0]    word_bits,
  output logic [SAMPLE_W-1:0] word_next,
  output logic                last_bit
);
  logic [SAMPLE_W-1:0] acc;
  logic                in_word;
  int                  pos;

  assign in_word  = (slot_idx < word_bits);
  assign pos      = SAMPLE_W - 1 - int'(slot_idx);
  assign last_bit = bit_tick && (slot_idx == word_bits - CNT_W'(1));

  always_comb begin
    word_next = slot_start ? '0 : acc;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (in_word && (i == pos)) word_next[i] = ser_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc <= '0;
    else if (bit_tick) acc <= word_next;
  end
endmodule

// File: rtl/sar_pair.sv
module sar_pair #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                last_bit,
  input  logic                slot_left,
  input  logic                synced,
  input  logic [SAMPLE_W-1:0] word_next,
  output logic [SAMPLE_W-1:0] left_word,
  output logic [SAMPLE_W-1:0] right_word,
  output logic                pair_valid
);
  logic [SAMPLE_W-1:0] left_hold;
  logic                left_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold  <= '0;
      left_ok    <= 1'b0;
      left_word  <= '0;
      right_word <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (last_bit && synced) begin
        if (slot_left) begin
          left_hold <= word_next;
          left_ok   <= 1'b1;
        end else if (left_ok) begin
          left_word  <= left_hold;
          right_word <= word_next;
          pair_valid <= 1'b1;
          left_ok    <= 1'b0;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid); // R6
  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(last_bit && !slot_left)); // R6
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> ($stable(left_word) && $stable(right_word))); // R6
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                frame_clk,
  input  logic                ser_data,
  input  logic                fmt_left_just,
  input  logic [1:0]          word_sel,
  output logic [SAMPLE_W-1:0] left_word,
  output logic [SAMPLE_W-1:0] right_word,
  output logic                pair_valid
);
  import sar_pkg::*;

  localparam int CNT_W = $clog2(SAMPLE_W + 1);

  logic                slot_start;
  logic [CNT_W-1:0]    slot_idx;
  logic                slot_left;
  logic                synced;
  logic [CNT_W-1:0]    word_bits;
  logic [SAMPLE_W-1:0] word_next;
  logic                last_bit;
  int                  sel_bits;

  assign sel_bits  = sar_word_bits(word_sel);
  assign word_bits = (sel_bits > SAMPLE_W) ? CNT_W'(SAMPLE_W) : CNT_W'(sel_bits);

  sar_slot_track #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_clk(frame_clk),
    .fmt_lj(fmt_left_just), .slot_start(slot_start), .slot_idx(slot_idx),
    .slot_left(slot_left), .synced(synced)
  );

  sar_shift #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ser_data(ser_data),
    .slot_start(slot_start), .slot_idx(slot_idx), .word_bits(word_bits),
    .word_next(word_next), .last_bit(last_bit)
  );

  sar_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .last_bit(last_bit), .slot_left(slot_left),
    .synced(synced), .word_next(word_next), .left_word(left_word),
    .right_word(right_word), .pair_valid(pair_valid)
  );

  AST_NO_PAIR_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(synced)); // R8
endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        frame_clk = 1'b0;
  logic        ser_data = 1'b0;
  logic        fmt_left_just = 1'b0;
  logic [1:0]  word_sel = 2'b00;
  logic [23:0] left_word, right_word;
  logic        pair_valid;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  // model state
  logic        m_sync;
  logic        m_left_ok;
  logic [23:0] m_left;
  logic [23:0] prev_right;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_clk(frame_clk),
    .ser_data(ser_data), .fmt_left_just(fmt_left_just), .word_sel(word_sel),
    .left_word(left_word), .right_word(right_word), .pair_valid(pair_valid)
  );

  function automatic int wbits(input logic [1:0] s);
    case (s)
      2'b00: return 16;
      2'b01: return 18;
      2'b10: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] keep_top(input logic [23:0] w, input int wl);
    logic [23:0] m;
    m = '0;
    for (int i = 0; i < 24; i++) if (i >= 24 - wl) m[i] = 1'b1;
    return w & m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_tick = 1'b0; frame_clk = 1'b0; ser_data = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_sync = 1'b0; m_left_ok = 1'b0; m_left = '0;
    prev_right = 24'($urandom);
  endtask

  // one bit tick; the model decides whether a pair must appear
  task automatic send_bit(input logic lvl, input logic d, input bit is_left,
                          input int k, input logic [23:0] word, input int wl, input bit lj);
    logic v1, v2;
    logic [23:0] gl, gr;
    bit exp_v;
    logic [23:0] el, er;
    logic level1;
    exp_v = 0; el = '0; er = '0;
    level1 = is_left ? lj : !lj;
    if (k == 0 && (m_sync || level1)) m_sync = 1'b1;
    if (m_sync && k == wl - 1) begin
      if (is_left) begin
        m_left = word; m_left_ok = 1'b1;
      end else if (m_left_ok) begin
        exp_v = 1; el = keep_top(m_left, wl); er = keep_top(word, wl); m_left_ok = 1'b0;
      end
    end
    @(negedge clk);
    frame_clk = lvl; ser_data = d; bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    v1 = pair_valid; gl = left_word; gr = right_word;
    // off-tick noise must be ignored (R1)
    frame_clk = 1'($urandom); ser_data = 1'($urandom);
    @(negedge clk);
    v2 = pair_valid;
    if (exp_v) begin
      check(v1 && gl == el && gr == er, lj ? "R1/R2/R4/R5 pair" : "R1/R2/R3/R5 pair",
            {gl, gr}, {el, er});
      check(!v2 && left_word == el && right_word == er, "R6 one-cycle strobe and hold",
            {23'b0, v2, right_word}, {24'b0, er});
    end else if (v1) begin
      check(0, "R8 unexpected pair", {gl, gr}, 48'b0);
    end
  endtask

  task automatic run_scenario(input bit lj, input int bpf, input logic [1:0] sel, input int frames);
    int s, wl;
    logic [23:0] lw, rw;
    s  = bpf / 2;
    fmt_left_just = lj; word_sel = sel;
    wl = wbits(sel);
    do_reset();
    for (int f = 0; f < frames; f++) begin
      lw = 24'($urandom); rw = 24'($urandom);
      for (int j = 0; j < bpf; j++) begin
        bit lf; int k; logic [23:0] w; logic lvl; logic d;
        if (lj) begin
          lf = (j < s); k = lf ? j : j - s; lvl = lf;
          w = lf ? lw : rw;
        end else begin
          lvl = (j < s) ? 1'b0 : 1'b1;
          if (j == 0) begin
            lf = 0; k = s - 1; w = prev_right;
          end else begin
            lf = (j - 1 < s); k = lf ? j - 1 : j - 1 - s;
            w = lf ? lw : rw;
          end
        end
        d = (k < wl) ? w[23 - k] : 1'($urandom);
        send_bit(lvl, d, lf, k, w, wl, lj);
      end
      prev_right = rw;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk);
    check(!pair_valid && left_word == 0 && right_word == 0, "R8 reset state",
          {left_word, right_word}, 48'b0);
    // directed: every frame length in both formats (R7)
    run_scenario(0, 32, 2'b00, 4);
    run_scenario(0, 48, 2'b11, 4);
    run_scenario(0, 64, 2'b01, 4);
    run_scenario(0, 72, 2'b10, 4);
    run_scenario(1, 64, 2'b11, 4);
    run_scenario(1, 48, 2'b10, 4);
    run_scenario(1, 72, 2'b00, 4);
    run_scenario(1, 32, 2'b00, 4);
    for (int n = 0; n < 16; n++) begin
      int bpf; logic [1:0] sel; bit lj;
      lj = 1'($urandom);
      case ($urandom % 4)
        0: bpf = 32;
        1: bpf = 48;
        2: bpf = 64;
        default: bpf = 72;
      endcase
      sel = (bpf == 32) ? 2'b00 : 2'($urandom);
      run_scenario(lj, bpf, sel, 4);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule